// File: doc/BRIEF.md
# Banked Serial EEPROM Access Sequencer

This block turns single-byte read and write requests into the command sequence that a two-wire byte engine needs in order to reach an array of identical serial EEPROMs. It presents the array as one flat address space. A 16-bit pointer holds the current location. Software-side logic can load the pointer, step it up or step it down. The sequencer splits the pointer into a device-select field and an in-device address.

The block drives four byte-engine commands. The engine confirms each command with a done pulse, and for transmitted bytes it also returns the acknowledge. If any transmitted byte is not acknowledged, the transfer is abandoned, a stop is still sent, and an error flag is raised. A device that is busy with an internal write cycle does not acknowledge its control byte, so a caller can poll for write completion by retrying until the error clears.

The user side is a one-cycle request with an opcode. The block answers with a one-cycle ready pulse and holds its results until the next accepted request.

Top module: `eeseq_top`

## Requirements
- R1: After reset, busy_o, ready_o, err_o, eng_valid_o, rdata_o and ptr_o are all zero.
- R2: Opcode 2 (load) sets ptr_o to ptr_i, with the high byte ANDed with TOT_MASK (default 0x3F). ready_o pulses in the cycle right after the accepting edge, and ptr_o shows the new value in that same cycle.
- R3: Opcode 3 (increment) adds one and carries from the low byte into the high byte. The high byte is then masked, so with the default mask 0x3FFF becomes 0x0000. ready_o pulses one cycle after acceptance.
- R4: Opcode 4 (decrement) subtracts one and borrows into the high byte. The high byte is then masked, so with the default mask 0x0000 becomes 0x3FFF.
- R5: The control byte is 1010 in bits 7:4 and the device select in bits 3:1. The device select is ((pointer high AND TOT_MASK) >> 4) with bit 0 cleared. Bit 0 of the control byte is 1 for read and 0 for write. For example, pointer 0x2003 gives 0xA2 for write and 0xA3 for read, and pointer 0x1FFF gives 0xA0.
- R6: The address-high byte sent is the pointer high byte ANDed with DEV_MASK (default 0x1F). For example, pointer 0x2003 sends 0x00.
- R7: Opcode 0 (write) issues the engine commands in this order: START, TX control(write), TX address-high, TX address-low, TX wdata, STOP. Engine command codes: 0 START, 1 STOP, 2 TX, 3 RX-without-acknowledge.
- R8: Opcode 1 (read) issues START, TX control(write), TX address-high, TX address-low, START, TX control(read), RX, STOP. The received byte appears on rdata_o when ready_o pulses.
- R9: If a TX is not acknowledged, no further byte is sent. The next command is STOP, err_o is 1 at the ready pulse, and rdata_o is not updated.
- R10: A write or read in which every TX is acknowledged ends with err_o at 0.
- R11: A request that arrives while busy_o is high is ignored. For example, a load issued during a read leaves ptr_o unchanged.
- R12: rdata_o and err_o keep their values from the ready pulse until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken only while idle |
| op_i | input | 3 | Opcode: 0 write, 1 read, 2 load, 3 increment, 4 decrement |
| ptr_i | input | 16 | Value for the load opcode |
| wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | A write or read transfer is in progress |
| ready_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last transfer hit a missing acknowledge |
| rdata_o | output | 8 | Last byte read |
| ptr_o | output | 16 | Current pointer |
| eng_valid_o | output | 1 | Command to byte engine valid, held until done |
| eng_cmd_o | output | 2 | Engine command code |
| eng_txd_o | output | 8 | Byte for a TX command |
| eng_done_i | input | 1 | Engine finished the current command |
| eng_ack_i | input | 1 | Acknowledge seen on the last TX |
| eng_rxd_i | input | 8 | Byte from an RX command, valid with done |

## Verification
Pointer opcodes finish on a fixed schedule. The ready pulse and the updated ptr_o both appear in the cycle after the accepting edge, so the bench samples at the first falling edge after that edge and requires a latency of zero waiting cycles. Transfers take as long as the byte engine does, so the bench waits for the ready pulse on falling edges. It then compares err_o, rdata_o and the command log that its engine-and-EEPROM model recorded. The model withholds acknowledge during a simulated write cycle and can refuse a chosen byte, which drives the abort and polling paths. The hold requirement is checked by sampling rdata_o and err_o again several idle cycles after the pulse.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;
  localparam int PTR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_WRITE = 3'd0,
    OP_READ  = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_TX    = 2'd2,
    BC_RX    = 2'd3
  } bcmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CTLW, ST_AHI, ST_ALO, ST_WDAT,
    ST_RSTART, ST_CTLR, ST_RX, ST_STOP
  } st_e;
endpackage

// File: rtl/eeseq_ptr.sv
module eeseq_ptr
  import eeseq_pkg::*;
#(
  parameter logic [PTR_W-BYTE_W-1:0] TOT_MASK = 'h3F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic [PTR_W-1:0] ld_val_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] SPACE = {TOT_MASK, {BYTE_W{1'b1}}};

  logic [PTR_W-1:0] nxt;

  always_comb begin
    if (ld_i)       nxt = ld_val_i;
    else if (inc_i) nxt = ptr_o + 1'b1;
    else if (dec_i) nxt = ptr_o - 1'b1;
    else            nxt = ptr_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ptr_o <= '0;
    else         ptr_o <= nxt & SPACE;

  a_r2_in_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_o & ~SPACE) == '0);
  a_r3_rollover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !ld_i && ptr_o == SPACE |=> ptr_o == '0);
  a_r4_rollunder: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !ld_i && !inc_i && ptr_o == '0 |=> ptr_o == SPACE);
endmodule

// File: rtl/eeseq_map.sv
module eeseq_map
  import eeseq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TOT_MASK = 8'h3F,
  parameter logic [BYTE_W-1:0] DEV_MASK = 8'h1F,
  parameter logic [3:0]        CTL_NIB  = 4'hA
) (
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] ctl_o,
  output logic [BYTE_W-1:0] ahi_o
);
  logic [BYTE_W-1:0] sel;

  always_comb begin
    // top pointer bits land in control bits 3:1
    sel   = ((hi_i & TOT_MASK) >> 4) & 8'hFE;
    ctl_o = (sel + {CTL_NIB, 4'h0}) | {7'd0, rd_i};
    ahi_o = hi_i & DEV_MASK;
  end

  always_comb begin
    a_r5_ctl_form: assert (ctl_o[7:4] == CTL_NIB && ctl_o[0] == rd_i);
    a_r6_dev_bound: assert ((ahi_o & ~DEV_MASK) == '0);
  end
endmodule

// File: rtl/eeseq_fsm.sv
module eeseq_fsm
  import eeseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  op_e               op_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] ctl_i,
  input  logic [BYTE_W-1:0] ahi_i,
  input  logic [BYTE_W-1:0] alo_i,
  output logic              rd_phase_o,
  output logic              ld_o,
  output logic              inc_o,
  output logic              dec_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              err_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              eng_valid_o,
  output bcmd_e             eng_cmd_o,
  output logic [BYTE_W-1:0] eng_txd_o,
  input  logic              eng_done_i,
  input  logic              eng_ack_i,
  input  logic [BYTE_W-1:0] eng_rxd_i
);
  st_e               st_q;
  logic              is_rd_q, fail_q;
  logic [BYTE_W-1:0] wbuf_q;
  logic              idle, accept, xfer_op, is_tx;

  assign idle    = (st_q == ST_IDLE);
  assign accept  = idle && req_i;
  assign xfer_op = (op_i == OP_WRITE) || (op_i == OP_READ);
  assign ld_o    = accept && op_i == OP_LOAD;
  assign inc_o   = accept && op_i == OP_INC;
  assign dec_o   = accept && op_i == OP_DEC;
  assign busy_o  = !idle;
  assign eng_valid_o = !idle;
  assign rd_phase_o  = (st_q == ST_CTLR);

  always_comb begin
    is_tx     = 1'b0;
    eng_txd_o = '0;
    case (st_q)
      ST_START, ST_RSTART: eng_cmd_o = BC_START;
      ST_CTLW, ST_CTLR: begin eng_cmd_o = BC_TX; is_tx = 1'b1; eng_txd_o = ctl_i; end
      ST_AHI:  begin eng_cmd_o = BC_TX; is_tx = 1'b1; eng_txd_o = ahi_i;  end
      ST_ALO:  begin eng_cmd_o = BC_TX; is_tx = 1'b1; eng_txd_o = alo_i;  end
      ST_WDAT: begin eng_cmd_o = BC_TX; is_tx = 1'b1; eng_txd_o = wbuf_q; end
      ST_RX:   eng_cmd_o = BC_RX;
      default: eng_cmd_o = BC_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      is_rd_q <= 1'b0;
      fail_q  <= 1'b0;
      wbuf_q  <= '0;
      ready_o <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ready_o <= 1'b0;
      if (accept) begin
        if (xfer_op) begin
          st_q    <= ST_START;
          is_rd_q <= (op_i == OP_READ);
          wbuf_q  <= wdata_i;
          fail_q  <= 1'b0;
        end else begin
          ready_o <= 1'b1;
        end
      end else if (!idle && eng_done_i) begin
        if (is_tx && !eng_ack_i) begin
          fail_q <= 1'b1;
          st_q   <= ST_STOP;
        end else begin
          case (st_q)
            ST_START:  st_q <= ST_CTLW;
            ST_CTLW:   st_q <= ST_AHI;
            ST_AHI:    st_q <= ST_ALO;
            ST_ALO:    st_q <= is_rd_q ? ST_RSTART : ST_WDAT;
            ST_WDAT:   st_q <= ST_STOP;
            ST_RSTART: st_q <= ST_CTLR;
            ST_CTLR:   st_q <= ST_RX;
            ST_RX: begin
              rdata_o <= eng_rxd_i;
              st_q    <= ST_STOP;
            end
            ST_STOP: begin
              st_q    <= ST_IDLE;
              ready_o <= 1'b1;
              err_o   <= fail_q;
            end
            default: st_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  a_r7_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o && !eng_done_i |=> eng_valid_o && $stable(eng_cmd_o) && $stable(eng_txd_o));
  a_r9_stop_after_nak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o && eng_done_i && eng_cmd_o == BC_TX && !eng_ack_i |=> eng_cmd_o == BC_STOP);
  a_r11_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_i && !eng_done_i |=> busy_o && !ready_o);
  a_r12_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && !req_i |=> $stable(rdata_o) && $stable(err_o));
endmodule

// File: rtl/eeseq_top.sv
module eeseq_top
  import eeseq_pkg::*;
#(
  parameter logic [7:0] TOT_MASK = 8'h3F,
  parameter logic [7:0] DEV_MASK = 8'h1F,
  parameter logic [3:0] CTL_NIB  = 4'hA
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [2:0]  op_i,
  input  logic [15:0] ptr_i,
  input  logic [7:0]  wdata_i,
  output logic        busy_o,
  output logic        ready_o,
  output logic        err_o,
  output logic [7:0]  rdata_o,
  output logic [15:0] ptr_o,
  output logic        eng_valid_o,
  output logic [1:0]  eng_cmd_o,
  output logic [7:0]  eng_txd_o,
  input  logic        eng_done_i,
  input  logic        eng_ack_i,
  input  logic [7:0]  eng_rxd_i
);
  logic              ld, inc, dec, rd_phase;
  logic [BYTE_W-1:0] ctl, ahi;
  bcmd_e             cmd;

  assign eng_cmd_o = cmd;

  eeseq_ptr #(.TOT_MASK(TOT_MASK)) u_ptr (
    .clk_i, .rst_ni,
    .ld_i(ld), .inc_i(inc), .dec_i(dec),
    .ld_val_i(ptr_i), .ptr_o
  );

  eeseq_map #(.TOT_MASK(TOT_MASK), .DEV_MASK(DEV_MASK), .CTL_NIB(CTL_NIB)) u_map (
    .hi_i(ptr_o[PTR_W-1:BYTE_W]), .rd_i(rd_phase), .ctl_o(ctl), .ahi_o(ahi)
  );

  eeseq_fsm u_fsm (
    .clk_i, .rst_ni, .req_i,
    .op_i(op_e'(op_i)), .wdata_i,
    .ctl_i(ctl), .ahi_i(ahi), .alo_i(ptr_o[BYTE_W-1:0]),
    .rd_phase_o(rd_phase), .ld_o(ld), .inc_o(inc), .dec_o(dec),
    .busy_o, .ready_o, .err_o, .rdata_o,
    .eng_valid_o, .eng_cmd_o(cmd), .eng_txd_o,
    .eng_done_i, .eng_ack_i, .eng_rxd_i
  );
endmodule

// File: tb/tb_eeseq_top.sv
module tb_eeseq_top;
  localparam int BUSY_CYC = 40;
  localparam logic [9:0] L_S = {2'd0, 8'h00};
  localparam logic [9:0] L_P = {2'd1, 8'h00};
  localparam logic [9:0] L_R = {2'd3, 8'h00};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] op = '0;
  logic [15:0] ptr_in = '0;
  logic [7:0] wd = '0;
  logic busy, ready, err, eng_valid;
  logic [7:0] rdata, eng_txd;
  logic [15:0] ptr;
  logic [1:0] eng_cmd;
  logic eng_done = 1'b0, eng_ack = 1'b0;
  logic [7:0] eng_rxd = '0;

  always #4 clk = ~clk;

  eeseq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .ptr_i(ptr_in),
    .wdata_i(wd), .busy_o(busy), .ready_o(ready), .err_o(err), .rdata_o(rdata),
    .ptr_o(ptr), .eng_valid_o(eng_valid), .eng_cmd_o(eng_cmd), .eng_txd_o(eng_txd),
    .eng_done_i(eng_done), .eng_ack_i(eng_ack), .eng_rxd_i(eng_rxd)
  );

  // byte engine plus two 8 KB EEPROMs, behavioural
  logic [7:0] mem [int];
  int   m_idx = 0, m_busy = 0, m_cnt = 0, nak_idx = -1;
  logic m_pend = 1'b0, m_sel = 1'b0, m_wpend = 1'b0;
  logic [2:0] m_dev = '0;
  logic [7:0] m_ahi = '0, m_alo = '0, m_wd = '0;
  logic [9:0] log_c [16];
  int   log_n = 0;

  function automatic int key();
    return int'(m_dev) * 8192 + int'(m_ahi & 8'h1F) * 256 + int'(m_alo);
  endfunction

  always @(posedge clk) begin
    logic a;
    if (m_busy > 0) m_busy = m_busy - 1;
    if (eng_done) begin
      eng_done <= 1'b0;
      m_pend = 1'b0;
    end else if (eng_valid && !m_pend) begin
      m_pend = 1'b1;
      m_cnt = 2;
    end else if (m_pend && m_cnt > 0) begin
      m_cnt = m_cnt - 1;
    end else if (m_pend) begin
      a = 1'b1;
      if (log_n < 16) log_c[log_n] = {eng_cmd, (eng_cmd == 2'd2) ? eng_txd : 8'h00};
      log_n = log_n + 1;
      case (eng_cmd)
        2'd0: m_idx = 0;
        2'd1: begin
          if (m_wpend) begin mem[key()] = m_wd; m_busy = BUSY_CYC; end
          m_wpend = 1'b0; m_sel = 1'b0;
        end
        2'd2: begin
          if (m_idx == 0) begin
            m_sel = eng_txd[7:4] == 4'hA && eng_txd[3:1] < 3'd2 && m_busy == 0;
            if (m_sel) m_dev = eng_txd[3:1];
          end
          a = m_sel && (m_idx != nak_idx);
          if (!a) m_sel = 1'b0;
          else if (m_idx == 1) m_ahi = eng_txd;
          else if (m_idx == 2) m_alo = eng_txd;
          else if (m_idx == 3) begin m_wd = eng_txd; m_wpend = 1'b1; end
          m_idx = m_idx + 1;
        end
        default: eng_rxd <= mem.exists(key()) ? mem[key()] : 8'hFF;
      endcase
      eng_ack  <= a;
      eng_done <= 1'b1;
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_op(input logic [2:0] o, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; op = o; ptr_in = a; wd = d; log_n = 0;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_ready(output int lat);
    lat = 0;
    while (!ready && lat < 2000) begin @(negedge clk); lat++; end
  endtask

  task automatic do_op(input logic [2:0] o, input logic [15:0] a, input logic [7:0] d, output int lat);
    start_op(o, a, d);
    wait_ready(lat);
  endtask

  task automatic poll(input logic [2:0] o, input logic [7:0] d);
    int lat;
    for (int t = 0; t < 30; t++) begin
      do_op(o, 16'h0, d, lat);
      if (!err) break;
    end
  endtask

  function automatic bit log_is(input logic [9:0] e [8], input int n);
    if (log_n != n) return 1'b0;
    for (int i = 0; i < n; i++) if (log_c[i] != e[i]) return 1'b0;
    return 1'b1;
  endfunction

  // op, argument, expected pointer
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {3'd2, 16'h1FFE, 16'h1FFE}, {3'd3, 16'h0, 16'h1FFF}, {3'd3, 16'h0, 16'h2000},
    {3'd4, 16'h0, 16'h1FFF},    {3'd2, 16'hFFF0, 16'h3FF0}, {3'd2, 16'h3FFF, 16'h3FFF},
    {3'd3, 16'h0, 16'h0000},    {3'd4, 16'h0, 16'h3FFF},  {3'd2, 16'h0000, 16'h0000},
    {3'd4, 16'h0, 16'h3FFF},    {3'd3, 16'h0, 16'h0000},  {3'd2, 16'h12FF, 16'h12FF},
    {3'd3, 16'h0, 16'h1300}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    logic [9:0] e [8];
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !ready && !err && !eng_valid && rdata == 0 && ptr == 0, "R1 reset",
          {busy, ready, err, eng_valid, rdata, ptr}, 0);
    rst_n = 1'b1;

    // R2 R3 R4 pointer vectors
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][34:32], VEC[i][31:16], 8'h0, lat);
      check(ptr == VEC[i][15:0] && lat == 0,
            (VEC[i][34:32] == 3'd2) ? "R2 load" : (VEC[i][34:32] == 3'd3) ? "R3 inc" : "R4 dec",
            {lat[15:0], ptr}, {16'd0, VEC[i][15:0]});
    end

    // R7 R5 R6 write at 0x2003
    do_op(3'd2, 16'h2003, 8'h0, lat);
    do_op(3'd0, 16'h0, 8'h55, lat);
    e = '{L_S, {2'd2, 8'hA2}, {2'd2, 8'h00}, {2'd2, 8'h03}, {2'd2, 8'h55}, L_P, 0, 0};
    check(log_is(e, 6), "R7 R5 R6 write sequence", log_n, 6);
    check(!err, "R10 write ok", err, 0);

    // R9 busy device refuses control byte
    do_op(3'd1, 16'h0, 8'h0, lat);
    e = '{L_S, {2'd2, 8'hA2}, L_P, 0, 0, 0, 0, 0};
    check(err && log_is(e, 3), "R9 nak on control", {err, log_n[7:0]}, {1'b1, 8'd3});

    // R8 poll until read succeeds
    poll(3'd1, 8'h0);
    e = '{L_S, {2'd2, 8'hA2}, {2'd2, 8'h00}, {2'd2, 8'h03}, L_S, {2'd2, 8'hA3}, L_R, L_P};
    check(log_is(e, 8), "R8 R5 read sequence", log_n, 8);
    check(rdata == 8'h55 && !err, "R8 R10 read data", {err, rdata}, {1'b0, 8'h55});

    // R12 results hold while idle
    repeat (5) @(negedge clk);
    check(rdata == 8'h55 && !err, "R12 hold", {err, rdata}, {1'b0, 8'h55});

    // R11 load during read is dropped
    do_op(3'd2, 16'h2003, 8'h0, lat);
    start_op(3'd1, 16'h0, 8'h0);
    req = 1'b1; op = 3'd2; ptr_in = 16'h0100;
    @(negedge clk);
    req = 1'b0;
    wait_ready(lat);
    check(ptr == 16'h2003 && rdata == 8'h55, "R11 busy request ignored", ptr, 16'h2003);

    // device boundary, 0x1FFC..0x2003
    do_op(3'd2, 16'h1FFC, 8'h0, lat);
    for (int i = 0; i < 8; i++) begin
      poll(3'd0, 8'h10 + 8'(i));
      check(!err, "R10 boundary write", err, 0);
      do_op(3'd3, 16'h0, 8'h0, lat);
    end
    check(mem.exists(8191) && mem[8191] == 8'h13, "R6 device0 top byte", mem[8191], 8'h13);
    check(mem.exists(8192) && mem[8192] == 8'h14, "R5 R6 device1 first byte", mem[8192], 8'h14);
    do_op(3'd2, 16'h1FFC, 8'h0, lat);
    for (int i = 0; i < 8; i++) begin
      poll(3'd1, 8'h0);
      check(rdata == 8'h10 + 8'(i) && !err, "R8 boundary readback", rdata, 8'h10 + 8'(i));
      do_op(3'd3, 16'h0, 8'h0, lat);
    end

    // R9 nak on address-high aborts without commit
    do_op(3'd2, 16'h0010, 8'h0, lat);
    poll(3'd0, 8'h33);
    repeat (BUSY_CYC + 10) @(negedge clk);
    nak_idx = 1;
    do_op(3'd0, 16'h0, 8'h99, lat);
    e = '{L_S, {2'd2, 8'hA0}, {2'd2, 8'h00}, L_P, 0, 0, 0, 0};
    check(err && log_is(e, 4), "R9 abort at address", {err, log_n[7:0]}, {1'b1, 8'd4});
    nak_idx = -1;
    repeat (BUSY_CYC + 10) @(negedge clk);
    poll(3'd1, 8'h0);
    check(rdata == 8'h33 && !err, "R9 R10 no commit after abort", rdata, 8'h33);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule